// File: doc/BRIEF.md
# Four-Phase Tick Clock with Dual-Rail Retractile Pipeline

This block is a cycle-accurate digital model of a four-phase clocking scheme that drives a pipeline of dual-rail buffer stages. A tick counter advances once per enabled clock edge. Each of the four phases is shown as a two-bit quantized trapezoid: low, rising, high or falling. Phase i rises in the tick whose number is i modulo 4, stays high for the next tick, falls in the tick after that, and rests low for one tick.

A chain of buffer stages carries a word of dual-rail bits forward. Stage k follows phase k modulo 4. It samples its input at the end of its phase's rising tick, drives the sampled value only while that phase is high, and returns its output to empty while the phase falls. Each stage therefore adds one tick of delay. A word that is offered in a tick numbered 0 modulo 4 leaves the last stage N_STAGES ticks later.

The sequencing is retractile. A stage's input may go back to empty while the stage holds a value, but it must not switch to a different valid value. An input bit with both rails asserted is illegal. Either violation sets a sticky error flag, which only reset clears.

Top module: `quad_phase_pipe`

## Requirements
- R1: Reset (rst, synchronous, active high) sets all phase fields to low, empties every rail of dout and clears err. The first enabled edge after reset starts tick 0.
- R2: phase_state holds phase i in bits [2i+1:2i], coded 0 low, 1 rising, 2 high, 3 falling. Phase i is rising in ticks t with t mod 4 = i, high when t mod 4 = (i+1) mod 4 and falling when t mod 4 = (i+2) mod 4. It is low in all other ticks, including every tick before its first rise.
- R3: A tick advances only on a clock edge with tick_en high. While tick_en is low, phase_state, dout and err hold.
- R4: Each data bit b is dual-rail: the zero rail is bit b of din_zero/dout_zero and the one rail is bit b of din_one/dout_one. Valid 0 is zero rail only, valid 1 is one rail only, and both low is empty. dout never has both rails of a bit high.
- R5: A word on din during a tick t with t mod 4 = 0 appears on dout during tick t+N_STAGES and in no other tick. In every other tick dout is empty.
- R6: Values on din during ticks with t mod 4 other than 0 are not captured, so dout stays empty for them.
- R7: One word per four ticks streams through without interference between consecutive words.
- R8: err rises at the end of any enabled tick in which some din bit has both rails high.
- R9: err rises at the end of an enabled tick in which a stage holds a bit and its input carries a different valid value for that bit. An empty input, or the same value, during that tick is not an error.
- R10: Once set, err stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advances one tick on the edge where it is high |
| din_zero | input | DATA_W | Zero rails of the input word |
| din_one | input | DATA_W | One rails of the input word |
| phase_state | output | 8 | Four 2-bit phase fields, phase i at [2i+1:2i] |
| dout_zero | output | DATA_W | Zero rails of the last stage |
| dout_one | output | DATA_W | One rails of the last stage |
| err | output | 1 | Sticky sequencing or rail-clash flag |

## Verification
Each phase field takes its new value at the edge that opens a tick. A word driven in tick t is due on dout in tick t+N_STAGES, and err is due in the tick after the offending one. The bench keeps a tick number that it increments only on enabled edges, drives din and samples all outputs 2 ns after each edge, and compares every value with the figure worked out for that tick number. Paused edges do not advance the count, so a hold window is checked against the values of the last tick.

// File: rtl/qpp_pkg.sv
package qpp_pkg;

   localparam int unsigned NUM_PHASES = 4;
   localparam int unsigned TICK_W     = $clog2(NUM_PHASES);

   typedef enum logic [1:0] {
      PH_LOW  = 2'd0,
      PH_RISE = 2'd1,
      PH_HIGH = 2'd2,
      PH_FALL = 2'd3
   } phase_e;

   // One tick of the trapezoid: a low phase rises only in its own slot.
   function automatic phase_e phase_step(input phase_e cur, input logic rise_slot);
      phase_e nxt;
      case (cur)
         PH_LOW:  nxt = rise_slot ? PH_RISE : PH_LOW;
         PH_RISE: nxt = PH_HIGH;
         PH_HIGH: nxt = PH_FALL;
         PH_FALL: nxt = PH_LOW;
         default: nxt = PH_LOW;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/qpp_tick_ctr.sv
module qpp_tick_ctr
   import qpp_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_en,
   output logic [TICK_W-1:0] tick_idx
);

   // tick_idx names the tick that the next enabled edge opens.
   always_ff @(posedge clk) begin
      if (rst)
         tick_idx <= '0;
      else if (tick_en)
         tick_idx <= tick_idx + 1'b1;
   end

endmodule

// File: rtl/qpp_phase_gen.sv
module qpp_phase_gen
   import qpp_pkg::*;
#(
   parameter int unsigned PH_IDX = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_en,
   input  logic [TICK_W-1:0] tick_idx,
   output phase_e            state
);

   localparam logic [TICK_W-1:0] SLOT = TICK_W'(PH_IDX);

   if (PH_IDX >= NUM_PHASES) begin : g_bad_idx
      $error("qpp_phase_gen: PH_IDX out of range");
   end

   always_ff @(posedge clk) begin
      if (rst)
         state <= PH_LOW;
      else if (tick_en)
         state <= phase_step(state, tick_idx == SLOT);
   end

endmodule

// File: rtl/qpp_rail_stage.sv
module qpp_rail_stage
   import qpp_pkg::*;
#(
   parameter int unsigned DATA_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_en,
   input  phase_e            ph,
   input  logic [DATA_W-1:0] in_zero,
   input  logic [DATA_W-1:0] in_one,
   output logic [DATA_W-1:0] out_zero,
   output logic [DATA_W-1:0] out_one,
   output logic              fault
);

   logic [DATA_W-1:0] both_hi;
   logic [DATA_W-1:0] in_valid;
   logic [DATA_W-1:0] held;
   logic [DATA_W-1:0] clash;

   assign both_hi  = in_zero & in_one;
   assign in_valid = in_zero ^ in_one;
   assign held     = out_zero | out_one;
   // Retraction to empty is allowed; only a different valid value clashes.
   assign clash    = held & in_valid & (in_one ^ out_one);
   assign fault    = tick_en & (|(both_hi | clash));

   always_ff @(posedge clk) begin
      if (rst) begin
         out_zero <= '0;
         out_one  <= '0;
      end else if (tick_en) begin
         case (ph)
            PH_RISE: begin
               out_zero <= in_zero & ~both_hi;
               out_one  <= in_one  & ~both_hi;
            end
            PH_HIGH: begin
               out_zero <= '0;
               out_one  <= '0;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/quad_phase_pipe.sv
module quad_phase_pipe
   import qpp_pkg::*;
#(
   parameter int unsigned N_STAGES = 4,
   parameter int unsigned DATA_W   = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    tick_en,
   input  logic [DATA_W-1:0]       din_zero,
   input  logic [DATA_W-1:0]       din_one,
   output logic [2*NUM_PHASES-1:0] phase_state,
   output logic [DATA_W-1:0]       dout_zero,
   output logic [DATA_W-1:0]       dout_one,
   output logic                    err
);

   if (N_STAGES < 1) begin : g_bad_stages
      $error("quad_phase_pipe: N_STAGES must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("quad_phase_pipe: DATA_W must be at least 1");
   end
   if (NUM_PHASES != 4) begin : g_bad_phases
      $error("quad_phase_pipe: exactly four phases are supported");
   end

   logic [TICK_W-1:0] tick_idx;
   phase_e            ph [NUM_PHASES];
   logic [DATA_W-1:0] chain_zero [N_STAGES+1];
   logic [DATA_W-1:0] chain_one  [N_STAGES+1];
   logic [N_STAGES-1:0] stage_fault;
   logic [N_STAGES-1:0] stage_occ;

   qpp_tick_ctr u_tick (
      .clk      (clk),
      .rst      (rst),
      .tick_en  (tick_en),
      .tick_idx (tick_idx)
   );

   for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
      qpp_phase_gen #(.PH_IDX(p)) u_ph (
         .clk      (clk),
         .rst      (rst),
         .tick_en  (tick_en),
         .tick_idx (tick_idx),
         .state    (ph[p])
      );
      assign phase_state[2*p +: 2] = ph[p];
   end

   assign chain_zero[0] = din_zero;
   assign chain_one[0]  = din_one;

   for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
      qpp_rail_stage #(.DATA_W(DATA_W)) u_stg (
         .clk      (clk),
         .rst      (rst),
         .tick_en  (tick_en),
         .ph       (ph[k % NUM_PHASES]),
         .in_zero  (chain_zero[k]),
         .in_one   (chain_one[k]),
         .out_zero (chain_zero[k+1]),
         .out_one  (chain_one[k+1]),
         .fault    (stage_fault[k])
      );
      assign stage_occ[k] = |(chain_zero[k+1] | chain_one[k+1]);
   end

   assign dout_zero = chain_zero[N_STAGES];
   assign dout_one  = chain_one[N_STAGES];

   always_ff @(posedge clk) begin
      if (rst)
         err <= 1'b0;
      else if (|stage_fault)
         err <= 1'b1;
   end

endmodule

// File: rtl/qpp_chk.sv
module qpp_chk #(
   parameter int unsigned N_STAGES = 4,
   parameter int unsigned DATA_W   = 2
) (
   input logic                clk,
   input logic                rst,
   input logic                tick_en,
   input logic [7:0]          phase_state,
   input logic [DATA_W-1:0]   dout_zero,
   input logic [DATA_W-1:0]   dout_one,
   input logic                err,
   input logic [N_STAGES-1:0] stg_occ
);

   logic [3:0] rise_flags;
   for (genvar i = 0; i < 4; i++) begin : g_rise
      assign rise_flags[i] = (phase_state[2*i +: 2] == 2'd1);

      p_rise_to_high_r2: assert property (@(posedge clk) disable iff (rst)
         (tick_en && phase_state[2*i +: 2] == 2'd1) |=> (phase_state[2*i +: 2] == 2'd2));
      p_high_to_fall_r2: assert property (@(posedge clk) disable iff (rst)
         (tick_en && phase_state[2*i +: 2] == 2'd2) |=> (phase_state[2*i +: 2] == 2'd3));
      p_fall_to_low_r2: assert property (@(posedge clk) disable iff (rst)
         (tick_en && phase_state[2*i +: 2] == 2'd3) |=> (phase_state[2*i +: 2] == 2'd0));
   end

   p_single_rise_r2: assert property (@(posedge clk) disable iff (rst)
      $onehot0(rise_flags));

   p_reset_state_r1: assert property (@(posedge clk)
      rst |=> (phase_state == 8'd0 && dout_zero == '0 && dout_one == '0 && !err));

   p_pause_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !tick_en |=> ($stable(phase_state) && $stable(dout_zero) && $stable(dout_one) && $stable(err)));

   p_rail_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
      (dout_zero & dout_one) == '0);

   for (genvar k = 0; k < N_STAGES; k++) begin : g_occ
      p_occupied_in_high_r5: assert property (@(posedge clk) disable iff (rst)
         stg_occ[k] |-> (phase_state[2*(k%4) +: 2] == 2'd2));
   end

   p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
      err |=> err);

endmodule

bind quad_phase_pipe qpp_chk #(.N_STAGES(N_STAGES), .DATA_W(DATA_W)) chk_i (
   .clk         (clk),
   .rst         (rst),
   .tick_en     (tick_en),
   .phase_state (phase_state),
   .dout_zero   (dout_zero),
   .dout_one    (dout_one),
   .err         (err),
   .stg_occ     (stage_occ)
);

// File: tb/quad_phase_pipe_tb_top.sv
module quad_phase_pipe_tb_top;

   localparam int unsigned NS = 4;
   localparam int unsigned DW = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          tick_en = 1'b0;
   logic [DW-1:0] din_zero = '0;
   logic [DW-1:0] din_one  = '0;
   logic [7:0]    phase_state;
   logic [DW-1:0] dout_zero;
   logic [DW-1:0] dout_one;
   logic          err;

   int checks = 0;
   int fails  = 0;
   int tick   = -1;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   quad_phase_pipe #(.N_STAGES(NS), .DATA_W(DW)) dut_i (
      .clk(clk), .rst(rst), .tick_en(tick_en),
      .din_zero(din_zero), .din_one(din_one),
      .phase_state(phase_state), .dout_zero(dout_zero), .dout_one(dout_one),
      .err(err)
   );

   function automatic logic [1:0] exp_phase(int t, int i);
      if (t < i) return 2'd0;
      case ((t - i) % 4)
         0: return 2'd1;
         1: return 2'd2;
         2: return 2'd3;
         default: return 2'd0;
      endcase
   endfunction

   function automatic logic [7:0] exp_all(int t);
      logic [7:0] v;
      for (int i = 0; i < 4; i++) v[2*i +: 2] = exp_phase(t, i);
      return v;
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_dout(string req, logic [DW-1:0] ez, logic [DW-1:0] eo);
      check(req, "dout_zero", 32'(dout_zero), 32'(ez));
      check(req, "dout_one",  32'(dout_one),  32'(eo));
   endtask

   task automatic step();
      tick_en = 1'b1;
      @(posedge clk);
      #2;
      tick++;
   endtask

   task automatic pause();
      tick_en = 1'b0;
      @(posedge clk);
      #2;
   endtask

   task automatic put(logic [DW-1:0] z, logic [DW-1:0] o);
      din_zero = z;
      din_one  = o;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      tick_en = 1'b0;
      put('0, '0);
      @(posedge clk);
      #2;
      rst = 1'b0;
      tick = -1;
   endtask

   task automatic to_cycle_start();
      step();
      while (tick % 4 != 0) step();
   endtask

   // R1: state straight after reset
   task automatic t_reset();
      do_reset();
      check("R1", "phase_state", 32'(phase_state), 32'd0);
      check_dout("R1", '0, '0);
      check("R1", "err", 32'(err), 32'd0);
   endtask

   // R2: phase trapezoids from the first tick, warm-up included
   task automatic t_phases();
      do_reset();
      for (int n = 0; n < 12; n++) begin
         step();
         check("R2", "phase_state", 32'(phase_state), 32'(exp_all(tick)));
      end
   endtask

   // R5, R4, R9: one word, latency of NS ticks, retraction of din allowed
   task automatic t_latency(logic [DW-1:0] v);
      do_reset();
      to_cycle_start();
      put(~v, v);
      for (int n = 1; n <= NS + 1; n++) begin
         step();
         put('0, '0);
         if (n == NS) check_dout("R5", ~v, v);
         else         check_dout("R5", '0, '0);
      end
      check("R9", "err after retraction", 32'(err), 32'd0);
   endtask

   // R7: one word per cycle streamed back to back
   task automatic t_stream();
      logic [DW-1:0] vals [4];
      vals[0] = 2'b01; vals[1] = 2'b10; vals[2] = 2'b11; vals[3] = 2'b00;
      do_reset();
      to_cycle_start();
      for (int r = 0; r <= 16; r++) begin
         if (r > 0) step();
         if (r >= 4 && r % 4 == 0) check_dout("R7", ~vals[r/4 - 1], vals[r/4 - 1]);
         else if (r > 0)           check_dout("R7", '0, '0);
         if (r % 4 == 0 && r < 16) put(~vals[r/4], vals[r/4]);
         else                      put('0, '0);
      end
      check("R7", "err", 32'(err), 32'd0);
   endtask

   // R6: data offered outside stage 0's rising tick is ignored
   task automatic t_window();
      do_reset();
      to_cycle_start();
      put('0, '0);
      for (int n = 1; n <= 8; n++) begin
         step();
         if (n >= 1 && n <= 3) put(2'b00, 2'b11);
         else                  put('0, '0);
         check_dout("R6", '0, '0);
      end
      check("R6", "err", 32'(err), 32'd0);
   endtask

   // R3: tick_en low freezes phases and data
   task automatic t_pause();
      logic [7:0] ps;
      do_reset();
      to_cycle_start();
      put(2'b10, 2'b01);
      for (int n = 1; n <= NS; n++) begin
         step();
         put('0, '0);
      end
      ps = phase_state;
      for (int n = 0; n < 5; n++) begin
         pause();
         check("R3", "phase_state held", 32'(phase_state), 32'(ps));
         check_dout("R3", 2'b10, 2'b01);
      end
      step();
      check("R3", "phase after resume", 32'(phase_state), 32'(exp_all(tick)));
      check_dout("R3", '0, '0);
   endtask

   // R9: same valid value kept during occupancy is legal; a new value is not
   task automatic t_clash();
      do_reset();
      to_cycle_start();
      put(2'b10, 2'b01);
      step();
      step();
      put('0, '0);
      check("R9", "err same value", 32'(err), 32'd0);
      do_reset();
      to_cycle_start();
      put(2'b10, 2'b01);
      step();
      put(2'b00, 2'b11);
      check("R9", "err before edge", 32'(err), 32'd0);
      step();
      put('0, '0);
      check("R9", "err after change", 32'(err), 32'd1);
   endtask

   // R8, R10, R1: both rails flag, stickiness, reset clears
   task automatic t_both_rails();
      do_reset();
      step(); step(); step();
      put(2'b01, 2'b01);
      check("R8", "err before edge", 32'(err), 32'd0);
      step();
      put('0, '0);
      check("R8", "err after both rails", 32'(err), 32'd1);
      for (int n = 0; n < 6; n++) step();
      check("R10", "err sticky", 32'(err), 32'd1);
      do_reset();
      check("R1", "err cleared", 32'(err), 32'd0);
   endtask

   initial begin
      t_reset();
      t_phases();
      t_latency(2'b01);
      t_latency(2'b10);
      t_stream();
      t_window();
      t_pause();
      t_clash();
      t_both_rails();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule